// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Interlock

This unit sits beside the register file in the decode stage of a five-stage in-order pipeline. Each cycle it takes the two source register numbers of the instruction being decoded and compares them against the destination numbers of the instructions currently in execute and in memory. It uses these comparisons to choose, for each operand passed on to the ID/EX register, one of three values: the register file read data, the execute-stage result, or the memory-stage write-back value. In this pipeline the write-back value is already fully selected in the memory stage, from load data, the ALU result or the link address. The register file is written at the edge that ends the memory stage.

Some execute-stage producers, such as loads, do not have their result ready in execute. When the instruction in decode needs such a result, the unit raises a front-end hold, which freezes the PC and the IF/ID register. It also raises a clear on ID/EX, which sends a bubble into execute. After one such cycle the producer has moved into the memory stage, and the memory-to-decode path then supplies the value. The unit is purely combinational. Every result depends only on the inputs in the same cycle.

Top module: `id_bypass_unit`

## Requirements
- R1: When neither stage matches a source number, the operand equals the register file read data for that source.
- R2: When the execute stage has write enable set, its destination equals a nonzero source number, and ex_early is 1 (its result is known in execute), the operand equals ex_result.
- R3: When only the memory stage matches a nonzero source number with write enable set, the operand equals mem_wb_data.
- R4: When both stages match the same source and ex_early is 1, the execute-stage value wins over the memory-stage value.
- R5: Source register number 0 is never forwarded and never causes a stall. Its operand is always the register file data.
- R6: A stage whose write enable is 0 never counts as a match, whatever its destination number.
- R7: When the execute stage matches either nonzero source with write enable set and ex_early is 0, front_hold and idex_clear are both 1 in that cycle.
- R8: front_hold and idex_clear are always equal, and both are 0 whenever the condition of R7 is absent.
- R9: During a stall, each operand takes the value it would have if execute did not match: mem_wb_data on a memory match, otherwise the register file data.
- R10: The rs and rt operands are resolved independently, so each one follows R1 to R6 on its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_num | input | REG_AW | First source register number in decode |
| id_rt_num | input | REG_AW | Second source register number in decode |
| rf_rs_data | input | DATA_W | Register file read data for the first source |
| rf_rt_data | input | DATA_W | Register file read data for the second source |
| ex_wen | input | 1 | Register write enable of the instruction in execute |
| ex_dst | input | REG_AW | Destination register number in execute |
| ex_early | input | 1 | 1 when the execute-stage result is available in execute |
| ex_result | input | DATA_W | Result computed in execute |
| mem_wen | input | 1 | Register write enable of the instruction in memory |
| mem_dst | input | REG_AW | Destination register number in memory |
| mem_wb_data | input | DATA_W | Final write-back value selected in the memory stage |
| id_a_data | output | DATA_W | First operand sent to ID/EX |
| id_b_data | output | DATA_W | Second operand sent to ID/EX |
| front_hold | output | 1 | Hold for the PC and IF/ID |
| idex_clear | output | 1 | Clear for ID/EX, inserting a bubble |

## Verification
Every output is a combinational function of the inputs of the same cycle, so each operand and both stall signals are due in the cycle a stimulus is applied. No register lies between input and output. The bench applies a new input combination at each falling clock edge and samples 2 ns later, well before the next rising edge, so each sample sees settled values for exactly that stimulus. With a 3-bit register number, the sweep covers every combination of both source numbers, both destinations, both write enables and the early-result flag. This includes all zero-register and same-register cases.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2
    } src_sel_e;

    // Newest usable producer first: execute (only if ready), then memory.
    function automatic src_sel_e pick_sel(input logic ex_hit,
                                          input logic ex_ready,
                                          input logic mem_hit);
        if (ex_hit && ex_ready)
            return SEL_EX;
        else if (mem_hit)
            return SEL_MEM;
        else
            return SEL_RF;
    endfunction

endpackage

// File: rtl/src_compare.sv
module src_compare
    import bypass_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_num,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_early,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_dst,
    output src_sel_e          sel,
    output logic              ex_wait
);

    logic nonzero;
    logic ex_hit;
    logic mem_hit;

    assign nonzero = |src_num;
    assign ex_hit  = nonzero && ex_wen  && (ex_dst  == src_num);
    assign mem_hit = nonzero && mem_wen && (mem_dst == src_num);
    assign sel     = pick_sel(ex_hit, ex_early, mem_hit);
    assign ex_wait = ex_hit && !ex_early;

    always_comb begin
        // R5
        zero_src_chk: assert (nonzero || (sel == SEL_RF && !ex_wait))
            else $error("register zero selected a bypass");
        // R6
        wen_gate_chk: assert ((sel != SEL_EX || ex_wen) && (sel != SEL_MEM || mem_wen))
            else $error("bypass chosen from a stage without write enable");
    end

endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] ex_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] op_data
);

    always_comb begin
        unique case (sel)
            SEL_EX:  op_data = ex_data;
            SEL_MEM: op_data = mem_data;
            default: op_data = rf_data;
        endcase
    end

endmodule

// File: rtl/interlock_ctrl.sv
module interlock_ctrl #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] wait_vec,
    output logic            hold,
    output logic            clear
);

    logic stall;

    assign stall = |wait_vec;
    assign hold  = stall;
    assign clear = stall;

endmodule

// File: rtl/id_bypass_unit.sv
module id_bypass_unit
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs_num,
    input  logic [REG_AW-1:0] id_rt_num,
    input  logic [DATA_W-1:0] rf_rs_data,
    input  logic [DATA_W-1:0] rf_rt_data,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_early,
    input  logic [DATA_W-1:0] ex_result,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [DATA_W-1:0] mem_wb_data,
    output logic [DATA_W-1:0] id_a_data,
    output logic [DATA_W-1:0] id_b_data,
    output logic              front_hold,
    output logic              idex_clear
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] src_nums;
    logic [NSRC-1:0][DATA_W-1:0] rf_vals;
    logic [NSRC-1:0][DATA_W-1:0] op_vals;
    src_sel_e                    sels [NSRC];
    logic [NSRC-1:0]             waits;

    assign src_nums = {id_rt_num, id_rs_num};
    assign rf_vals  = {rf_rt_data, rf_rs_data};

    // R10: each source has its own comparator and selector
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        src_compare #(.REG_AW(REG_AW)) u_cmp (
            .src_num (src_nums[i]),
            .ex_wen  (ex_wen),
            .ex_dst  (ex_dst),
            .ex_early(ex_early),
            .mem_wen (mem_wen),
            .mem_dst (mem_dst),
            .sel     (sels[i]),
            .ex_wait (waits[i])
        );

        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sels[i]),
            .rf_data (rf_vals[i]),
            .ex_data (ex_result),
            .mem_data(mem_wb_data),
            .op_data (op_vals[i])
        );
    end

    interlock_ctrl #(.NSRC(NSRC)) u_lock (
        .wait_vec(waits),
        .hold    (front_hold),
        .clear   (idex_clear)
    );

    assign id_a_data = op_vals[0];
    assign id_b_data = op_vals[1];

    logic load_use;
    assign load_use = ex_wen && !ex_early && (|ex_dst) &&
                      ((ex_dst == id_rs_num) || (ex_dst == id_rt_num));

    always_comb begin
        // R7
        load_stall_chk: assert (front_hold == load_use)
            else $error("hold disagrees with the load-use condition");
        // R8
        hold_clear_pair_chk: assert (front_hold == idex_clear)
            else $error("hold and clear differ");
        // R9
        stall_no_ex_chk: assert (!front_hold || (sels[0] != SEL_EX && sels[1] != SEL_EX))
            else $error("execute value selected during a stall");
    end

endmodule

// File: tb/sim_id_bypass_unit.sv
module sim_id_bypass_unit;

    localparam int DW = 16;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] rs, rt, exd, memd;
    logic [DW-1:0] rfa, rfb, exr, memv;
    logic          exw, memw, early;
    logic [DW-1:0] a_out, b_out;
    logic          hold, clr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    id_bypass_unit #(.DATA_W(DW), .REG_AW(AW)) u0 (
        .id_rs_num  (rs),
        .id_rt_num  (rt),
        .rf_rs_data (rfa),
        .rf_rt_data (rfb),
        .ex_wen     (exw),
        .ex_dst     (exd),
        .ex_early   (early),
        .ex_result  (exr),
        .mem_wen    (memw),
        .mem_dst    (memd),
        .mem_wb_data(memv),
        .id_a_data  (a_out),
        .id_b_data  (b_out),
        .front_hold (hold),
        .idex_clear (clr)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (rs=%0d rt=%0d exw=%0d exd=%0d early=%0d memw=%0d memd=%0d)",
                     tag, act, exp, rs, rt, exw, exd, early, memw, memd);
        end
    endtask

    // Expected operand from the requirements, with the requirement it exercises.
    task automatic expect_op(input int src, input logic [DW-1:0] rfv,
                             output logic [DW-1:0] v, output string tag);
        bit exm, mm;
        exm = (src != 0) && exw  && (int'(exd)  == src);
        mm  = (src != 0) && memw && (int'(memd) == src);
        if (src == 0) begin
            v = rfv; tag = "R5";
        end else if (exm && early) begin
            v = exr; tag = mm ? "R4" : "R2";
        end else if (exm) begin
            v = mm ? memv : rfv; tag = "R9";
        end else if (mm) begin
            v = memv; tag = "R3";
        end else begin
            v = rfv;
            tag = ((int'(exd) == src && !exw) || (int'(memd) == src && !memw)) ? "R6" : "R1";
        end
    endtask

    initial begin
        rs = '0; rt = '0; exd = '0; memd = '0;
        exw = 0; memw = 0; early = 0;
        rfa = 16'h0000; rfb = 16'h0000; exr = 16'hE0E0; memv = 16'hC0C0;
        @(negedge clk);
        #2;
        // Idle state: all zeros, no hazard (R1, R8)
        check("R1 idle a", a_out, 16'h0000);
        check("R1 idle b", b_out, 16'h0000);
        check("R8 idle hold", {15'd0, hold}, 16'd0);
        check("R8 idle clear", {15'd0, clr}, 16'd0);

        for (int c = 0; c < 32768; c++) begin
            logic [DW-1:0] ea, eb;
            string ta, tb;
            bit stall_exp;
            @(negedge clk);
            rs    = c[2:0];
            rt    = c[5:3];
            exd   = c[8:6];
            memd  = c[11:9];
            exw   = c[12];
            memw  = c[13];
            early = c[14];
            rfa   = 16'h1000 + DW'(c[2:0]);
            rfb   = 16'h2000 + DW'(c[5:3]);
            exr   = 16'hE000 ^ DW'(c[8:0]);
            memv  = 16'hC000 ^ DW'(c[11:3]);
            #2;
            expect_op(int'(rs), rfa, ea, ta);
            expect_op(int'(rt), rfb, eb, tb);
            // R10: rs and rt judged separately
            check({ta, " a"}, a_out, ea);
            check({tb, " b (R10)"}, b_out, eb);
            stall_exp = exw && !early && (exd != 0) && (exd == rs || exd == rt);
            check(stall_exp ? "R7 hold" : "R8 hold", {15'd0, hold}, {15'd0, stall_exp});
            check(stall_exp ? "R7 clear" : "R8 clear", {15'd0, clr}, {15'd0, stall_exp});
        end
        done = 1;
    end

    initial begin
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule